// File: doc/BRIEF.md
# Keypad Scanner with Key Buffer

This block scans a 20-key matrix of five rows by four columns and refreshes a six-digit multiplexed display. One shared 4-bit scan value is used for both jobs. A programmable prescaler advances the scan value through eight states. The first six states each enable one active-low digit select and drive that digit's byte from a small display memory. The first five states each pull one keypad row low. The block then watches four column return lines, which idle high.

A key closure is checked on successive scans of its row before it is accepted. Once a key is accepted, the whole matrix is locked until that key has been seen open again on several scans. Accepted codes go into an eight-entry queue. An interrupt line stays high for as long as the queue holds a code.

A host reaches the block through a two-address port. With the address bit low, a read returns key data and a write goes to the display memory. With the address bit high, a read returns status and a write is a command.

Top module: `kpd_scanner`

## Requirements
- R1: The scan value on `scan_code` steps once every (L+1) clock cycles, where L is the prescaler limit. It counts 0 to 7 and then wraps to 0.
- R2: For scan values 0 to 5, only `digit_sel_n[scan]` is low and `seg_data` shows the display byte stored for that digit. For scan values 6 and 7, all digit selects are high and `seg_data` is 0.
- R3: For scan values 0 to 4, only `row_drive_n[scan]` is low. For scan values 5 to 7, no row is driven.
- R4: A closure must be seen on two consecutive scans of its row before it is accepted. Its code is {row[2:0], column[1:0]} in bits 4:0 of the key data, with bits 7:5 zero. If several columns of one row close together, the lowest column number wins.
- R5: After a key is accepted, no other key is accepted until that key has been seen open on two consecutive scans of its row. Any other closure in that time has no effect.
- R6: The key queue holds 8 codes. A data read returns the oldest code and removes it. A data read from an empty queue returns 0.
- R7: `irq` is high from the cycle after a code is stored. It drops in the cycle after the read that empties the queue.
- R8: The status read gives the fill count in bits 3:0 and an overflow flag in bit 5. An accepted key that finds the queue full is dropped and sets the flag. The flag stays set until command 0xC0 is written.
- R9: A command byte with bits 7:5 = 001 loads bits 4:0 as the prescaler limit and restarts the prescale count.
- R10: A command byte with bits 7:5 = 100 sets the display write pointer to bits 2:0 and auto-increment to bit 4. A data write stores the byte at the pointer. With auto-increment on, the pointer then advances and wraps from digit 5 to digit 0.
- R11: Reset sets the control state to its defaults: scan 0, prescaler limit 3, pointer 0 with no auto-increment, empty queue, flag clear, `irq` low. Display contents are kept.
- R12: A closure that is seen on only one scan of its row and then found open is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Port select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_a0 | input | 1 | 0 = key data / display data, 1 = status / command |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | High while a key code is waiting |
| col_n | input | 4 | Column return lines, low when pressed |
| scan_code | output | 4 | Current scan value |
| digit_sel_n | output | 6 | Active-low digit selects |
| seg_data | output | 8 | Byte for the selected digit |
| row_drive_n | output | 5 | Active-low keypad row drives |

## Verification
A wrong scan or prescale count shows up at once, within one tick period, as a mismatch on `scan_code`, the digit selects or the row drives. The bench model checks these on every cycle. A debounce or lockout state that has gone astray has no effect on the pins until the next scan of the affected row. At that point it adds or drops a queued code, so it shows up in `irq` and the status fill count within two to three full scan periods. A queue pointer fault shows up as a wrong code or order on the very next data read.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int SCAN_W = 4;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 2;
    localparam int NUM_COLS = 4;

    typedef enum logic [1:0] {
        KS_IDLE    = 2'd0,
        KS_CONFIRM = 2'd1,
        KS_HELD    = 2'd2
    } key_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_code_t;

    typedef enum logic [2:0] {
        OP_PRESC  = 3'b001,
        OP_DPTR   = 3'b100,
        OP_CLROVF = 3'b110
    } cmd_op_e;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic       ovf;
        logic       spare_lo;
        logic [3:0] fill;
    } status_t;

    // lowest-numbered column whose return line is pulled low
    function automatic logic [COL_W-1:0] first_low(input logic [NUM_COLS-1:0] cols);
        logic [COL_W-1:0] idx;
        idx = '0;
        for (int i = NUM_COLS - 1; i >= 0; i--) begin
            if (!cols[i]) idx = COL_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/kpd_scan_timer.sv
module kpd_scan_timer
    import kpd_pkg::*;
#(
    parameter int PRESC_W       = 5,
    parameter int PRESC_DEFAULT = 3,
    parameter int SCAN_STATES   = 8,
    parameter int NUM_DIGITS    = 6,
    parameter int NUM_ROWS      = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lim_load,
    input  logic [PRESC_W-1:0]    lim_val,
    output logic                  tick,
    output logic [SCAN_W-1:0]     scan,
    output logic [NUM_DIGITS-1:0] digit_sel_n,
    output logic [NUM_ROWS-1:0]   row_drive_n
);
    localparam logic [SCAN_W-1:0]  SCAN_LAST = SCAN_W'(SCAN_STATES - 1);
    localparam logic [PRESC_W-1:0] LIM_RST   = PRESC_W'(PRESC_DEFAULT);

    logic [PRESC_W-1:0] presc_cnt;
    logic [PRESC_W-1:0] presc_lim;

    assign tick = (presc_cnt == presc_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_cnt <= '0;
            presc_lim <= LIM_RST;
            scan      <= '0;
        end else begin
            if (lim_load) begin
                presc_lim <= lim_val;
                presc_cnt <= '0;
            end else if (tick) begin
                presc_cnt <= '0;
            end else begin
                presc_cnt <= presc_cnt + 1'b1;
            end
            if (tick) begin
                scan <= (scan == SCAN_LAST) ? '0 : scan + 1'b1;
            end
        end
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        assign digit_sel_n[d] = (scan != SCAN_W'(d));
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_drive_n[r] = (scan != SCAN_W'(r));
    end

endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
    import kpd_pkg::*;
#(
    parameter int NUM_ROWS    = 5,
    parameter int DEB_PRESS   = 2,
    parameter int DEB_RELEASE = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [SCAN_W-1:0]   scan,
    input  logic [NUM_COLS-1:0] col_n,
    output logic                accept,
    output key_code_t           code
);
    localparam int DEB_MAX = (DEB_PRESS > DEB_RELEASE) ? DEB_PRESS : DEB_RELEASE;
    localparam int CW      = $clog2(DEB_MAX + 1);
    localparam logic [CW-1:0] PRESS_N   = CW'(DEB_PRESS);
    localparam logic [CW-1:0] RELEASE_N = CW'(DEB_RELEASE);

    key_state_e state, state_n;
    key_code_t  cand, cand_n;
    logic [CW-1:0] hits, hits_n;
    logic [CW-1:0] rel, rel_n;

    logic            row_valid;
    logic [ROW_W-1:0] row;
    logic            any_low;
    logic            on_cand_row;

    assign row_valid   = tick && (scan < SCAN_W'(NUM_ROWS));
    assign row         = scan[ROW_W-1:0];
    assign any_low     = ~&col_n;
    assign on_cand_row = row_valid && (row == cand.row);

    always_comb begin
        state_n = state;
        cand_n  = cand;
        hits_n  = hits;
        rel_n   = rel;
        accept  = 1'b0;
        case (state)
            KS_IDLE: begin
                if (row_valid && any_low) begin
                    cand_n.row = row;
                    cand_n.col = first_low(col_n);
                    if (PRESS_N <= CW'(1)) begin
                        accept  = 1'b1;
                        state_n = KS_HELD;
                        rel_n   = '0;
                    end else begin
                        hits_n  = CW'(1);
                        state_n = KS_CONFIRM;
                    end
                end
            end
            KS_CONFIRM: begin
                if (on_cand_row) begin
                    if (!col_n[cand.col]) begin
                        if ((hits + CW'(1)) >= PRESS_N) begin
                            accept  = 1'b1;
                            state_n = KS_HELD;
                            rel_n   = '0;
                        end else begin
                            hits_n = hits + CW'(1);
                        end
                    end else begin
                        state_n = KS_IDLE;
                    end
                end
            end
            KS_HELD: begin
                if (on_cand_row) begin
                    if (col_n[cand.col]) begin
                        if ((rel + CW'(1)) >= RELEASE_N) begin
                            state_n = KS_IDLE;
                        end else begin
                            rel_n = rel + CW'(1);
                        end
                    end else begin
                        rel_n = '0;
                    end
                end
            end
            default: state_n = KS_IDLE;
        endcase
    end

    assign code = cand_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= KS_IDLE;
            cand  <= '0;
            hits  <= '0;
            rel   <= '0;
        end else begin
            state <= state_n;
            cand  <= cand_n;
            hits  <= hits_n;
            rel   <= rel_n;
        end
    end

endmodule

// File: rtl/kpd_fifo.sv
module kpd_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           full,
    output logic                           empty
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (fill == FILL_MAX);
    assign empty   = (fill == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // storage is kept across reset; only the pointers restart
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/kpd_disp.sv
module kpd_disp
    import kpd_pkg::*;
#(
    parameter int NUM_DIGITS = 6
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   ptr_load,
    input  logic [$clog2(NUM_DIGITS)-1:0]          ptr_val,
    input  logic                                   ai_val,
    input  logic                                   data_wr,
    input  logic [7:0]                             wdata,
    input  logic [SCAN_W-1:0]                      scan,
    output logic [7:0]                             seg_data
);
    localparam int DPTR_W = $clog2(NUM_DIGITS);
    localparam logic [DPTR_W-1:0] PTR_LAST = DPTR_W'(NUM_DIGITS - 1);

    logic [7:0]        mem [NUM_DIGITS];
    logic [DPTR_W-1:0] ptr;
    logic              auto_inc;
    logic              ptr_in_range;

    assign ptr_in_range = ({{(32-DPTR_W){1'b0}}, ptr} < NUM_DIGITS);

    always_ff @(posedge clk) begin
        if (data_wr && ptr_in_range) mem[ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            auto_inc <= 1'b0;
        end else if (ptr_load) begin
            ptr      <= ptr_val;
            auto_inc <= ai_val;
        end else if (data_wr && auto_inc) begin
            ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        if (scan < SCAN_W'(NUM_DIGITS)) seg_data = mem[scan[DPTR_W-1:0]];
        else                            seg_data = 8'h00;
    end

endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
    import kpd_pkg::*;
#(
    parameter int NUM_DIGITS    = 6,
    parameter int NUM_ROWS      = 5,
    parameter int SCAN_STATES   = 8,
    parameter int FIFO_DEPTH    = 8,
    parameter int DEB_PRESS     = 2,
    parameter int DEB_RELEASE   = 2,
    parameter int PRESC_W       = 5,
    parameter int PRESC_DEFAULT = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_cs,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  bus_a0,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  irq,
    input  logic [3:0]            col_n,
    output logic [3:0]            scan_code,
    output logic [NUM_DIGITS-1:0] digit_sel_n,
    output logic [7:0]            seg_data,
    output logic [NUM_ROWS-1:0]   row_drive_n
);
    localparam int CODE_W = $bits(key_code_t);
    localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
    localparam int DPTR_W = $clog2(NUM_DIGITS);

    logic        tick;
    logic        accept;
    key_code_t   acc_code;
    logic [CODE_W-1:0] fifo_dout;
    logic [FILL_W-1:0] fifo_fill;
    logic        fifo_full, fifo_empty;
    logic        pop, push, drop;
    logic        cmd_wr, data_wr;
    logic        lim_load, ptr_load, ovf_clr;
    logic        ovf_q;
    status_t     status;

    assign cmd_wr   = bus_cs && bus_wr && bus_a0;
    assign data_wr  = bus_cs && bus_wr && !bus_a0;
    assign lim_load = cmd_wr && (bus_wdata[7:5] == OP_PRESC);
    assign ptr_load = cmd_wr && (bus_wdata[7:5] == OP_DPTR);
    assign ovf_clr  = cmd_wr && (bus_wdata[7:5] == OP_CLROVF);

    assign pop  = bus_cs && bus_rd && !bus_a0 && !fifo_empty;
    assign push = accept && (!fifo_full || pop);
    assign drop = accept && fifo_full && !pop;

    kpd_scan_timer #(
        .PRESC_W      (PRESC_W),
        .PRESC_DEFAULT(PRESC_DEFAULT),
        .SCAN_STATES  (SCAN_STATES),
        .NUM_DIGITS   (NUM_DIGITS),
        .NUM_ROWS     (NUM_ROWS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .lim_load   (lim_load),
        .lim_val    (bus_wdata[PRESC_W-1:0]),
        .tick       (tick),
        .scan       (scan_code),
        .digit_sel_n(digit_sel_n),
        .row_drive_n(row_drive_n)
    );

    kpd_debounce #(
        .NUM_ROWS   (NUM_ROWS),
        .DEB_PRESS  (DEB_PRESS),
        .DEB_RELEASE(DEB_RELEASE)
    ) u_deb (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .scan  (scan_code),
        .col_n (col_n),
        .accept(accept),
        .code  (acc_code)
    );

    kpd_fifo #(
        .DEPTH(FIFO_DEPTH),
        .WIDTH(CODE_W)
    ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .din  (acc_code),
        .pop  (pop),
        .dout (fifo_dout),
        .fill (fifo_fill),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    kpd_disp #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_disp (
        .clk     (clk),
        .rst     (rst),
        .ptr_load(ptr_load),
        .ptr_val (bus_wdata[DPTR_W-1:0]),
        .ai_val  (bus_wdata[4]),
        .data_wr (data_wr),
        .wdata   (bus_wdata),
        .scan    (scan_code),
        .seg_data(seg_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (drop)         ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;

            if (push)                                   irq <= 1'b1;
            else if (pop && fifo_fill == FILL_W'(1))    irq <= 1'b0;
        end
    end

    always_comb begin
        status          = '0;
        status.ovf      = ovf_q;
        status.fill     = 4'(fifo_fill);
        if (bus_a0)          bus_rdata = status;
        else if (fifo_empty) bus_rdata = 8'h00;
        else                 bus_rdata = 8'(fifo_dout);
    end

endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk #(
    parameter int NUM_DIGITS = 6,
    parameter int NUM_ROWS   = 5,
    parameter int FIFO_DEPTH = 8,
    parameter int FILL_W     = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic [3:0]            scan_code,
    input logic [NUM_DIGITS-1:0] digit_sel_n,
    input logic [NUM_ROWS-1:0]   row_drive_n,
    input logic                  irq,
    input logic [FILL_W-1:0]     fifo_fill,
    input logic                  fifo_full,
    input logic                  accept,
    input logic                  pop,
    input logic                  ovf_q
);

    assert_scan_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(scan_code));

    assert_digit_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~digit_sel_n));

    assert_digit_blank_R2: assert property (@(posedge clk) disable iff (rst)
        (scan_code >= 4'(NUM_DIGITS)) |-> (&digit_sel_n));

    assert_row_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_drive_n));

    assert_row_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (scan_code >= 4'(NUM_ROWS)) |-> (&row_drive_n));

    assert_single_accept_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_fill <= FILL_W'(FIFO_DEPTH));

    assert_irq_tracks_fill_R7: assert property (@(posedge clk) disable iff (rst)
        irq == (fifo_fill != '0));

    assert_overflow_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && fifo_full && !pop) |=> ovf_q);

endmodule

bind kpd_scanner kpd_scanner_chk #(
    .NUM_DIGITS(NUM_DIGITS),
    .NUM_ROWS  (NUM_ROWS),
    .FIFO_DEPTH(FIFO_DEPTH),
    .FILL_W    (FILL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .scan_code  (scan_code),
    .digit_sel_n(digit_sel_n),
    .row_drive_n(row_drive_n),
    .irq        (irq),
    .fifo_fill  (fifo_fill),
    .fifo_full  (fifo_full),
    .accept     (accept),
    .pop        (pop),
    .ovf_q      (ovf_q)
);

// File: tb/kpd_scanner_tb.sv
module kpd_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [3:0] col_n;
    logic [3:0] scan_code;
    logic [5:0] digit_sel_n;
    logic [7:0] seg_data;
    logic [4:0] row_drive_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 0;

    // keypad model: two keys may be held
    bit k1_on = 0, k2_on = 0;
    int k1_r = 0, k1_c = 0, k2_r = 0, k2_c = 0;

    kpd_scanner u_dut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .col_n(col_n), .scan_code(scan_code), .digit_sel_n(digit_sel_n),
        .seg_data(seg_data), .row_drive_n(row_drive_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        col_n = 4'hF;
        for (int r = 0; r < 5; r++) begin
            if (!row_drive_n[r]) begin
                if (k1_on && k1_r == r) col_n[k1_c] = 1'b0;
                if (k2_on && k2_r == r) col_n[k2_c] = 1'b0;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_scan, m_pc, m_lim, m_st, m_cr, m_cc, m_hits, m_rel, m_ptr;
    bit m_ai, m_ovf;
    int m_q[$];
    logic [7:0] m_disp [6];
    bit m_known [6];

    function automatic bit closed(int r, int c);
        return (k1_on && k1_r == r && k1_c == c) || (k2_on && k2_r == r && k2_c == c);
    endfunction

    initial for (int i = 0; i < 6; i++) m_known[i] = 0;

    always @(posedge clk) begin
        bit tk, acc, ovf_set, clr;
        int op;
        if (rst) begin
            m_scan = 0; m_pc = 0; m_lim = 3; m_st = 0; m_hits = 0; m_rel = 0;
            m_cr = 0; m_cc = 0; m_ptr = 0; m_ai = 0; m_ovf = 0;
            m_q.delete();
        end else begin
            tk = (m_pc == m_lim);
            acc = 0; ovf_set = 0; clr = 0;
            if (tk && m_scan < 5) begin
                if (m_st == 0) begin
                    for (int c = 0; c < 4; c++) begin
                        if (m_st == 0 && closed(m_scan, c)) begin
                            m_cr = m_scan; m_cc = c; m_hits = 1; m_st = 1;
                        end
                    end
                end else if (m_st == 1) begin
                    if (m_scan == m_cr) begin
                        if (closed(m_cr, m_cc)) begin
                            m_hits++;
                            if (m_hits >= 2) begin acc = 1; m_st = 2; m_rel = 0; end
                        end else m_st = 0;
                    end
                end else begin
                    if (m_scan == m_cr) begin
                        if (!closed(m_cr, m_cc)) begin
                            m_rel++;
                            if (m_rel >= 2) m_st = 0;
                        end else m_rel = 0;
                    end
                end
            end
            if (tk) begin m_scan = (m_scan + 1) % 8; m_pc = 0; end
            else m_pc++;
            if (bus_cs && bus_rd && !bus_a0 && m_q.size() > 0) void'(m_q.pop_front());
            if (acc) begin
                if (m_q.size() < 8) m_q.push_back(m_cr * 4 + m_cc);
                else ovf_set = 1;
            end
            if (bus_cs && bus_wr && bus_a0) begin
                op = int'(bus_wdata[7:5]);
                if (op == 1) begin m_lim = int'(bus_wdata[4:0]); m_pc = 0; end
                if (op == 4) begin m_ptr = int'(bus_wdata[2:0]); m_ai = bus_wdata[4]; end
                if (op == 6) clr = 1;
            end
            if (ovf_set) m_ovf = 1; else if (clr) m_ovf = 0;
            if (bus_cs && bus_wr && !bus_a0) begin
                if (m_ptr < 6) begin m_disp[m_ptr] = bus_wdata; m_known[m_ptr] = 1; end
                if (m_ai) m_ptr = (m_ptr == 5) ? 0 : (m_ptr + 1) % 8;
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        logic [5:0] exp_dig;
        logic [4:0] exp_row;
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (started) begin
            for (int d = 0; d < 6; d++) exp_dig[d] = !(m_scan == d);
            for (int r = 0; r < 5; r++) exp_row[r] = !(m_scan == r);
            chk({4'h0, scan_code}, 8'(m_scan), "R1 scan value");
            chk({2'b0, digit_sel_n}, {2'b0, exp_dig}, "R2 digit select");
            chk({3'b0, row_drive_n}, {3'b0, exp_row}, "R3 row drive");
            chk({7'b0, irq}, {7'b0, m_q.size() != 0}, "R7 irq vs model");
            if (m_scan >= 6) chk(seg_data, 8'h00, "R2 blank digit");
            else if (m_known[m_scan]) chk(seg_data, m_disp[m_scan], "R2 digit data");
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic a0, input logic [7:0] d);
        @(negedge clk); #1;
        bus_cs = 1; bus_wr = 1; bus_a0 = a0; bus_wdata = d;
        @(negedge clk); #1;
        bus_cs = 0; bus_wr = 0; bus_a0 = 0; bus_wdata = 8'h00;
    endtask

    task automatic bus_read(input logic a0, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        bus_cs = 1; bus_rd = 1; bus_a0 = a0;
        #1 chk(bus_rdata, exp, tag);
        @(negedge clk); #1;
        bus_cs = 0; bus_rd = 0; bus_a0 = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scan(input int v);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #2;
            if (scan_code == 4'(v)) break;
        end
    endtask

    task automatic key1(input bit on, input int r, input int c);
        @(negedge clk); #1;
        k1_on = on; k1_r = r; k1_c = c;
    endtask

    task automatic key2(input bit on, input int r, input int c);
        @(negedge clk); #1;
        k2_on = on; k2_r = r; k2_c = c;
    endtask

    initial begin
        int s0;
        idle(3); #1;
        rst = 0; started = 1;
        // R11: reset state
        #1;
        chk({4'h0, scan_code}, 8'h00, "R11 scan after reset");
        chk({7'b0, irq}, 8'h00, "R11 irq after reset");
        chk({2'b0, digit_sel_n}, 8'h3E, "R11 digit 0 selected after reset");
        bus_read(1, 8'h00, "R11 status after reset");

        // R10: auto-increment writes with wrap, then fixed pointer
        bus_write(1, 8'h90);
        for (int i = 1; i <= 7; i++) bus_write(0, 8'(i * 8'h11));
        bus_write(1, 8'h83);
        bus_write(0, 8'hA5);
        bus_write(0, 8'h5A);
        wait_scan(0);
        chk(seg_data, 8'h77, "R10 wrapped write lands on digit 0");
        wait_scan(3);
        chk(seg_data, 8'h5A, "R10 fixed pointer overwrite");
        wait_scan(5);
        chk(seg_data, 8'h66, "R2 digit 5 data");
        wait_scan(6);
        chk(seg_data, 8'h00, "R2 blank at scan 6");
        chk({2'b0, digit_sel_n}, 8'h3F, "R2 no digit at scan 6");
        chk({3'b0, row_drive_n}, 8'h1F, "R3 no row at scan 6");

        // R4 / R7 / R6: single key at row 2 column 1 -> code 9
        key1(1, 2, 1);
        idle(130);
        chk({7'b0, irq}, 8'h01, "R7 irq raised after store");
        key1(0, 0, 0);
        idle(130);
        bus_read(1, 8'h01, "R4 one key stored");
        bus_read(0, 8'h09, "R4 code row2 col1");
        chk({7'b0, irq}, 8'h00, "R7 irq cleared by read");
        bus_read(0, 8'h00, "R6 empty read returns zero");

        // R12: a closure seen on only one scan is rejected
        wait_scan(7);
        key1(1, 0, 0);
        idle(10);
        key1(0, 0, 0);
        idle(130);
        bus_read(1, 8'h00, "R12 bounce not accepted");

        // R5: lockout while a key is held
        key1(1, 1, 3);
        idle(130);
        key2(1, 1, 0);
        idle(80);
        key2(0, 0, 0);
        key2(1, 4, 0);
        idle(80);
        key1(0, 0, 0);
        idle(250);
        key2(0, 0, 0);
        idle(150);
        bus_read(1, 8'h02, "R5 only two keys stored");
        bus_read(0, 8'h07, "R5 held key first");
        bus_read(0, 8'h10, "R5 waiting key after release");

        // R4: lowest column wins when two columns close together
        key1(1, 3, 2);
        key2(1, 3, 1);
        idle(130);
        key1(0, 0, 0);
        key2(0, 0, 0);
        idle(130);
        bus_read(0, 8'h0D, "R4 lowest column wins");

        // R8 / R6: overflow and ordering
        for (int i = 0; i < 9; i++) begin
            key1(1, i / 4, i % 4);
            idle(130);
            key1(0, 0, 0);
            idle(130);
        end
        bus_read(1, 8'h28, "R8 full with overflow flag");
        for (int i = 0; i < 8; i++) bus_read(0, 8'(i), "R6 order oldest first");
        bus_read(0, 8'h00, "R6 read after drain");
        bus_read(1, 8'h20, "R8 flag sticky after drain");
        bus_write(1, 8'hC0);
        bus_read(1, 8'h00, "R8 flag cleared by command");

        // R9 / R1: prescaler limit 0 -> step every cycle
        bus_write(1, 8'h20);
        @(negedge clk); #2 s0 = int'(scan_code);
        @(negedge clk); #2 chk({4'h0, scan_code}, 8'((s0 + 1) % 8), "R9 limit 0 steps each cycle");
        bus_write(1, 8'h22);
        idle(60);

        // R11: reset keeps display, restores control state
        key1(1, 4, 3);
        idle(100);
        key1(0, 0, 0);
        idle(60);
        @(negedge clk); #1 rst = 1;
        idle(2); #1 rst = 0;
        #1 chk({7'b0, irq}, 8'h00, "R11 irq low after reset");
        bus_read(1, 8'h00, "R11 queue empty after reset");
        wait_scan(3);
        chk(seg_data, 8'h5A, "R11 display kept digit 3");
        wait_scan(1);
        chk(seg_data, 8'h22, "R11 display kept digit 1");
        idle(40);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule